// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether an incoming Ethernet frame is kept or discarded, based on its 48-bit destination address and its length. The receive path presents the address, the frame length and a small control word together with a one-cycle valid strobe. One cycle later the filter returns a registered keep/discard decision and a set of flags that name every rule that matched.

Three exact-match rules are evaluated in parallel: two programmable station addresses and the all-ones broadcast address. Each has its own enable bit. A fourth rule handles multicast. It folds the address down to a 6-bit index and looks that index up in a 64-entry table of bits, which software fills for the groups it has joined. The table can act as a coarse filter for individual addresses too. Frames that are too short to carry a full address header are discarded whatever their address.

The configuration words are plain input ports. They are expected to be driven by a register decoder outside the block.

Top module: `rx_da_filter`

## Requirements
- R1: A strobed frame whose length is below 12 bytes is dropped: `dec_accept` is 0 and `dec_cause` is 0, whatever the address and control bits. A length of 12 or more is subject to the address rules.
- R2: When `flt_ctrl[0]` is 1 and the address equals station address 0, `dec_cause[0]` is set. When `flt_ctrl[0]` is 0, that bit is never set. Station address 0 is `{st0_hi[15:0], st0_lo[31:0]}`, so byte 0 sits in `st0_lo[7:0]` and byte 5 in `st0_hi[15:8]`.
- R3: In the same way, `flt_ctrl[1]` enables comparison with station address 1, `{st1_hi, st1_lo}`, and reports a hit in `dec_cause[1]`.
- R4: When `flt_ctrl[3]` is 1 and all 48 address bits are 1, `dec_cause[2]` is set. Otherwise it is 0.
- R5: The table lookup is made only when address bit 0 (bit 0 of the first byte on the wire, the group flag) is 1, or when `flt_ctrl[2]` is 1. If neither holds, `dec_cause[3]` is 0.
- R6: Address bit p is bit (p mod 8) of wire byte (p div 8), carried on `in_dest[p]`. Index bit k (0 to 5) is the XOR of every address bit p with p mod 6 equal to k.
- R7: An index from 0 to 31 selects that bit of `grp_tbl_lo`. An index from 32 to 63 selects bit (index minus 32) of `grp_tbl_hi`. A 1 in the selected bit sets `dec_cause[3]`.
- R8: `dec_accept` is 1 exactly when at least one bit of `dec_cause` is 1. All rules that match are reported at the same time.
- R9: `dec_valid` is 1 in the cycle after a cycle with `in_valid` high, and 0 otherwise. Inputs are sampled only on the strobe, so `dec_accept` and `dec_cause` hold their values until the next strobe, however the inputs change in between.
- R10: During and after reset, `dec_valid`, `dec_accept` and `dec_cause` are 0 until the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | One-cycle strobe: the inputs below are valid |
| in_dest | input | 48 | Destination address; bits 7:0 are the first byte on the wire |
| in_len | input | 16 | Frame length in bytes |
| flt_ctrl | input | 4 | Enables: 0 station 0, 1 station 1, 2 table for individual addresses, 3 broadcast |
| st0_lo | input | 32 | Station address 0, bytes 0 to 3 |
| st0_hi | input | 16 | Station address 0, bytes 4 and 5 |
| st1_lo | input | 32 | Station address 1, bytes 0 to 3 |
| st1_hi | input | 16 | Station address 1, bytes 4 and 5 |
| grp_tbl_lo | input | 32 | Group table entries 0 to 31 |
| grp_tbl_hi | input | 32 | Group table entries 32 to 63 |
| dec_valid | output | 1 | Decision valid, one cycle after the strobe |
| dec_accept | output | 1 | Keep the frame |
| dec_cause | output | 4 | Matching rules: 0 station 0, 1 station 1, 2 broadcast, 3 table |

## Verification
The hardest situation to reach from the ports is a chosen table index, since the index is a scattered XOR of all 48 address bits. A random address almost never lands on a given table entry. The bench therefore takes a random upper address and solves for the lowest six bits, so that the fold gives each index from 0 to 63 in turn. It checks a hit with a one-hot table and a miss with the complementary table. Every control word is then crossed with station, broadcast, group and individual addresses, and the length is swept across the 12-byte boundary.

// File: rtl/rx_daf_pkg.sv
package rx_daf_pkg;
  localparam int ADDR_W  = 48;
  localparam int RULES_N = 4;

  // Positions of the rule flags in dec_cause
  localparam int C_ST0   = 0;
  localparam int C_ST1   = 1;
  localparam int C_BCAST = 2;
  localparam int C_TABLE = 3;

  // Positions of the control bits
  localparam int K_ST0   = 0;
  localparam int K_ST1   = 1;
  localparam int K_INDIV = 2;
  localparam int K_BCAST = 3;

  typedef logic [ADDR_W-1:0]  mac_t;
  typedef logic [RULES_N-1:0] cause_t;
endpackage

// File: rtl/rx_daf_exact.sv
module rx_daf_exact
  import rx_daf_pkg::*;
(
  input  mac_t dest,
  input  mac_t ref_addr,
  input  logic enable,
  output logic hit
);
  always_comb begin
    hit = enable && (dest == ref_addr);
  end
endmodule

// File: rtl/rx_daf_hash.sv
module rx_daf_hash
  import rx_daf_pkg::*;
#(
  parameter int HASH_W = 6,
  localparam int TBL_W = 1 << HASH_W
)(
  input  mac_t             dest,
  input  logic [TBL_W-1:0] table_bits,
  input  logic             indiv_ok,
  output logic [HASH_W-1:0] index,
  output logic             hit
);
  logic [HASH_W-1:0] fold;
  logic              applies;

  // Each index bit is the parity of the address bits at the same position mod HASH_W
  always_comb begin
    fold = '0;
    for (int p = 0; p < ADDR_W; p++) begin
      fold[p % HASH_W] = fold[p % HASH_W] ^ dest[p];
    end
  end

  always_comb begin
    index   = fold;
    applies = dest[0] || indiv_ok;
    hit     = applies && table_bits[fold];
  end
endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
  import rx_daf_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 12,
  parameter int HASH_W  = 6,
  localparam int TBL_W  = 1 << HASH_W,
  localparam int HALF_W = TBL_W / 2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [47:0]       in_dest,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [3:0]        flt_ctrl,
  input  logic [31:0]       st0_lo,
  input  logic [15:0]       st0_hi,
  input  logic [31:0]       st1_lo,
  input  logic [15:0]       st1_hi,
  input  logic [HALF_W-1:0] grp_tbl_lo,
  input  logic [HALF_W-1:0] grp_tbl_hi,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic [3:0]        dec_cause
);
  localparam int EXACT_N = 3;

  mac_t                      exact_ref [EXACT_N];
  logic [EXACT_N-1:0]        exact_en;
  logic [EXACT_N-1:0]        exact_hit;
  logic [HASH_W-1:0]         tbl_index;
  logic                      tbl_hit;
  logic                      len_ok;
  cause_t                    hits;

  cause_t cause_d, cause_q;
  logic   accept_d, accept_q;
  logic   valid_d, valid_q;

  always_comb begin
    exact_ref[0] = {st0_hi, st0_lo};
    exact_ref[1] = {st1_hi, st1_lo};
    exact_ref[2] = '1;
    exact_en[0]  = flt_ctrl[K_ST0];
    exact_en[1]  = flt_ctrl[K_ST1];
    exact_en[2]  = flt_ctrl[K_BCAST];
  end

  for (genvar g = 0; g < EXACT_N; g++) begin : g_exact
    rx_daf_exact u_exact (
      .dest     (in_dest),
      .ref_addr (exact_ref[g]),
      .enable   (exact_en[g]),
      .hit      (exact_hit[g])
    );
  end

  rx_daf_hash #(.HASH_W(HASH_W)) u_hash (
    .dest       (in_dest),
    .table_bits ({grp_tbl_hi, grp_tbl_lo}),
    .indiv_ok   (flt_ctrl[K_INDIV]),
    .index      (tbl_index),
    .hit        (tbl_hit)
  );

  always_comb begin
    len_ok         = (in_len >= LEN_W'(MIN_LEN));
    hits           = '0;
    hits[C_ST0]    = exact_hit[0];
    hits[C_ST1]    = exact_hit[1];
    hits[C_BCAST]  = exact_hit[2];
    hits[C_TABLE]  = tbl_hit;
  end

  // Next state: decision registers are enabled by the strobe only
  always_comb begin
    valid_d  = in_valid;
    cause_d  = cause_q;
    accept_d = accept_q;
    if (in_valid) begin
      cause_d  = len_ok ? hits : '0;
      accept_d = len_ok && (hits != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      cause_q  <= '0;
      accept_q <= 1'b0;
    end else begin
      valid_q  <= valid_d;
      cause_q  <= cause_d;
      accept_q <= accept_d;
    end
  end

  assign dec_valid  = valid_q;
  assign dec_accept = accept_q;
  assign dec_cause  = cause_q;
endmodule

// File: rtl/rx_daf_chk.sv
module rx_daf_chk #(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 12
)(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [47:0]      in_dest,
  input logic [LEN_W-1:0] in_len,
  input logic [3:0]       flt_ctrl,
  input logic             dec_valid,
  input logic             dec_accept,
  input logic [3:0]       dec_cause
);
  // R9
  strobe_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> dec_valid);
  // R9
  no_strobe_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !dec_valid);
  // R9
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(dec_cause) && $stable(dec_accept)));
  // R1
  short_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_len < LEN_W'(MIN_LEN))) |=> (!dec_accept && dec_cause == 4'd0));
  // R2
  st0_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !flt_ctrl[0]) |=> !dec_cause[0]);
  // R3
  st1_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !flt_ctrl[1]) |=> !dec_cause[1]);
  // R4
  bcast_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && flt_ctrl[3] && in_dest == 48'hFFFF_FFFF_FFFF && in_len >= LEN_W'(MIN_LEN))
      |=> (dec_accept && dec_cause[2]));
  // R5
  indiv_no_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_dest[0] && !flt_ctrl[2]) |=> !dec_cause[3]);
  // R8
  accept_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_accept == (dec_cause != 4'd0)));
endmodule

bind rx_da_filter rx_daf_chk #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_dest    (in_dest),
  .in_len     (in_len),
  .flt_ctrl   (flt_ctrl),
  .dec_valid  (dec_valid),
  .dec_accept (dec_accept),
  .dec_cause  (dec_cause)
);

// File: tb/rx_da_filter_bench.sv
`timescale 1ns/1ps
module rx_da_filter_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [47:0] in_dest;
  logic [15:0] in_len;
  logic [3:0]  flt_ctrl;
  logic [31:0] st0_lo, st1_lo, grp_tbl_lo, grp_tbl_hi;
  logic [15:0] st0_hi, st1_hi;
  logic        dec_valid, dec_accept;
  logic [3:0]  dec_cause;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rx_da_filter u_rx_da_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
    .in_len(in_len), .flt_ctrl(flt_ctrl), .st0_lo(st0_lo), .st0_hi(st0_hi),
    .st1_lo(st1_lo), .st1_hi(st1_hi), .grp_tbl_lo(grp_tbl_lo),
    .grp_tbl_hi(grp_tbl_hi), .dec_valid(dec_valid), .dec_accept(dec_accept),
    .dec_cause(dec_cause)
  );

  // Index by 6-bit chunks: XOR of eight slices, same as parity by position mod 6
  function automatic logic [5:0] fold6(input logic [47:0] a);
    logic [5:0] h = '0;
    for (int c = 0; c < 8; c++) h = h ^ 6'((a >> (6 * c)) & 48'h3f);
    return h;
  endfunction

  function automatic logic [3:0] model(input logic [47:0] a, input int len,
                                       input logic [3:0] k);
    logic [3:0] r = '0;
    logic [63:0] tbl = {grp_tbl_hi, grp_tbl_lo};
    if (len < 12) return 4'd0;
    r[0] = k[0] && (a == {st0_hi, st0_lo});
    r[1] = k[1] && (a == {st1_hi, st1_lo});
    r[2] = k[3] && (a == 48'hFFFF_FFFF_FFFF);
    r[3] = (a[0] || k[2]) && tbl[fold6(a)];
    return r;
  endfunction

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got valid/accept/cause=%b expected %b", req, act, exp);
    end
  endtask

  task automatic run_case(input logic [47:0] a, input int len,
                          input logic [3:0] k, input string req);
    logic [3:0] e;
    @(negedge clk);
    in_dest = a; in_len = 16'(len); flt_ctrl = k; in_valid = 1'b1;
    e = model(a, len, k);
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {dec_valid, dec_accept, dec_cause}, {1'b1, (e != 4'd0), e});
  endtask

  initial begin
    logic [47:0] base;
    logic [47:0] addr;
    logic [3:0]  last;
    rst_n = 1'b0; in_valid = 1'b0; in_dest = '0; in_len = '0; flt_ctrl = '0;
    st0_lo = 32'h4433_2211; st0_hi = 16'h6655;
    st1_lo = 32'hDDCC_BBAA; st1_hi = 16'h01EE;
    grp_tbl_lo = '0; grp_tbl_hi = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", {dec_valid, dec_accept, dec_cause}, 6'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", {dec_valid, dec_accept, dec_cause}, 6'd0);

    // R6 R7: every table index, hit with a one-hot table, miss with its complement
    for (int h = 0; h < 64; h++) begin
      base = {$urandom(), 16'($urandom())} & ~48'h3f;
      addr = base | 48'(6'(h) ^ fold6(base));
      {grp_tbl_hi, grp_tbl_lo} = 64'd1 << h;
      run_case(addr, 64, 4'b0100, "R6/R7 index hit");
      {grp_tbl_hi, grp_tbl_lo} = ~(64'd1 << h);
      run_case(addr, 64, 4'b0100, "R6/R7 index miss");
    end

    // R2 R3 R4 R5 R8: every control word against each address kind
    for (int k = 0; k < 16; k++) begin
      grp_tbl_lo = $urandom(); grp_tbl_hi = $urandom();
      run_case({st0_hi, st0_lo}, 60, 4'(k), "R2 station 0");
      run_case({st1_hi, st1_lo}, 60, 4'(k), "R3 station 1");
      run_case(48'hFFFF_FFFF_FFFF, 60, 4'(k), "R4 broadcast");
      base = {$urandom(), 16'($urandom())};
      run_case(base | 48'h1, 60, 4'(k), "R5 group");
      run_case(base & ~48'h1, 60, 4'(k), "R5 individual");
      {grp_tbl_hi, grp_tbl_lo} = '1;
      run_case(base & ~48'h1, 60, 4'(k), "R5 individual full table");
      run_case(base | 48'h1, 60, 4'(k), "R8 group full table");
    end

    // R1: length sweep across the boundary, with every rule able to hit
    {grp_tbl_hi, grp_tbl_lo} = '1;
    for (int len = 0; len < 16; len++) begin
      run_case(48'hFFFF_FFFF_FFFF, len, 4'b1111, "R1 length");
      run_case({st0_hi, st0_lo}, len, 4'b0001, "R1 length");
    end

    // R9: inputs moving without a strobe leave the decision untouched
    run_case({st1_hi, st1_lo}, 30, 4'b0010, "R9 setup");
    last = model({st1_hi, st1_lo}, 30, 4'b0010);
    @(negedge clk);
    in_dest = 48'hFFFF_FFFF_FFFF; flt_ctrl = 4'b1111; in_len = 16'd5;
    repeat (3) @(negedge clk);
    check("R9 hold", {dec_valid, dec_accept, dec_cause}, {1'b0, 1'b1, last});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule